// File: doc/BRIEF.md
# Parallel Fitness Evaluation Controller with Maximum Reduction

This block sits between a requester and a bank of NF identical scoring units. When the requester offers a batch of NF candidates, the block forwards every candidate to its own unit and raises one shared start strobe, so all units begin together. Each unit finishes after its own number of cycles and reports a score with a done pulse. The block keeps each unit's first reported score. It does nothing further until every unit has reported.

Once the last unit has reported, the NF scores pass through a registered tree of pairwise comparators. The first level has NF/2 comparators, and each later level has half as many as the one before it, until a single survivor remains. Each comparator keeps the larger of its two signed (two's complement) scores. It also carries along the number of the unit that produced that score, and on equal scores the lower-numbered unit wins. The surviving score and unit number are offered to the requester on a valid/ready output.

The request side follows valid/ready rules: a batch is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the block is idle. The result side holds `res_valid`, `res_score` and `res_index` unchanged until `res_ready` is seen high. If `res_ready` is already high, the result lasts a single cycle. NF is a power of two from 2 to 64. The unit-side pins are plain control and data lines.

Top module: `par_eval_ctrl`

## Requirements
- R1: `req_ready` is high only while idle. In the cycle after a batch is taken, `unit_start` is high for exactly one cycle and `unit_cand[i*CW +: CW]` holds the candidate that was offered at `req_cand[i*CW +: CW]`.
- R2: For each unit i, the score `unit_score[i*SW +: SW]` is captured in the first cycle, from the start cycle onward, in which `unit_done[i]` is high. Score values offered without done, and further done pulses from a unit that has already reported, have no effect.
- R3: No result appears before all NF units have reported. If the last done pulse comes in cycle d (cycle 0 being the `unit_start` cycle), then `res_valid` first goes high in cycle d + log2(NF) + 1.
- R4: `res_score` equals the largest of the NF captured scores, compared as signed two's complement.
- R5: `res_index` is the unit number of that largest score. When several units share it, the lowest unit number is given.
- R6: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_score` and `res_index` stay unchanged. In the cycle after `res_ready` is seen high, `res_valid` is low and `req_ready` is high.
- R7: A request offered while a batch is in progress is not taken. It produces no further `unit_start` and does not change the result.
- R8: During and right after reset, `req_ready` is high, and `res_valid` and `unit_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Batch offered |
| req_ready | output | 1 | Block is idle and takes a batch |
| req_cand | input | NF*CW | Candidates, slot i at bits i*CW +: CW |
| unit_start | output | 1 | Start strobe shared by all units |
| unit_cand | output | NF*CW | Candidate for each unit, slot i at bits i*CW +: CW |
| unit_done | input | NF | Done pulse from each unit |
| unit_score | input | NF*SW | Score from each unit, slot i at bits i*SW +: SW |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Requester takes the result |
| res_score | output | SW | Largest signed score |
| res_index | output | log2(NF) | Unit number of the largest score |

## Verification
The bench counts cycles from the `unit_start` cycle, which is the cycle after the request handshake. For each batch it finds the last done cycle d from the latencies it picked, and then checks that `res_valid` stays low in every cycle up to d + log2(NF) and is high in cycle d + log2(NF) + 1. Score and index are compared in that first valid cycle. They are compared again in every held cycle while `res_ready` is low. The cycle after the release must show `res_valid` low and `req_ready` high. All sampling is done on the falling clock edge, so each check reads values that settled after the last rising edge.

// File: rtl/pe_pkg.sv
package pe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_REDUCE = 2'd2,
    ST_RESULT = 2'd3
  } pe_state_e;

endpackage

// File: rtl/pe_ctrl_fsm.sv
module pe_ctrl_fsm
  import pe_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      all_done,
  input  logic      root_load,
  input  logic      res_ready,
  output pe_state_e state,
  output logic      req_ready,
  output logic      accept,
  output logic      launch,
  output logic      cap_en,
  output logic      res_valid
);

  pe_state_e state_q, state_d;

  assign state     = state_q;
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign cap_en    = (state_q == ST_WAIT);
  assign launch    = cap_en && all_done;
  assign res_valid = (state_q == ST_RESULT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_WAIT;
      ST_WAIT:   if (launch) state_d = root_load ? ST_RESULT : ST_REDUCE;
      ST_REDUCE: if (root_load) state_d = ST_RESULT;
      ST_RESULT: if (res_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pe_score_capture.sv
module pe_score_capture #(
  parameter int NF = 8,
  parameter int SW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   cap_en,
  input  logic [NF-1:0]          done,
  input  logic [NF-1:0][SW-1:0]  score_in,
  output logic [NF-1:0][SW-1:0]  score_q,
  output logic                   all_done
);

  logic [NF-1:0] flag;

  for (genvar i = 0; i < NF; i++) begin : g_unit
    logic          seen_q;
    logic [SW-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_q <= 1'b0;
        held_q <= '0;
      end else if (clr) begin
        seen_q <= 1'b0;
      end else if (cap_en && done[i] && !seen_q) begin
        seen_q <= 1'b1;
        held_q <= score_in[i];
      end
    end

    assign flag[i]    = seen_q;
    assign score_q[i] = held_q;
  end

  assign all_done = &flag;

endmodule

// File: rtl/pe_max_node.sv
module pe_max_node #(
  parameter int SW = 16,
  parameter int IW = 3
) (
  input  logic [SW-1:0] a_val,
  input  logic [IW-1:0] a_idx,
  input  logic [SW-1:0] b_val,
  input  logic [IW-1:0] b_idx,
  output logic [SW-1:0] o_val,
  output logic [IW-1:0] o_idx
);

  // the right-hand input comes from higher unit numbers, so it wins only
  // when strictly larger
  logic take_b;
  assign take_b = $signed(b_val) > $signed(a_val);
  assign o_val  = take_b ? b_val : a_val;
  assign o_idx  = take_b ? b_idx : a_idx;

endmodule

// File: rtl/pe_max_tree.sv
module pe_max_tree #(
  parameter int NF = 8,
  parameter int SW = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        launch,
  input  logic [NF-1:0][SW-1:0]       leaf,
  output logic                        root_load,
  output logic [SW-1:0]               max_val,
  output logic [$clog2(NF)-1:0]       max_idx
);

  localparam int L  = $clog2(NF);
  localparam int IW = L;
  localparam int NN = 2 * NF;

  // heap numbering: node 1 is the root, nodes NF..2NF-1 are the leaves
  logic [SW-1:0] nv [1:NN-1];
  logic [IW-1:0] ni [1:NN-1];

  // go[k] loads tree level k+1
  logic [L-1:0] go;

  if (L == 1) begin : g_go_one
    assign go = launch;
  end else begin : g_go_many
    logic [L-2:0] go_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) go_q <= '0;
      else        go_q <= go[L-2:0];
    end
    assign go = {go_q, launch};
  end

  assign root_load = go[L-1];

  for (genvar i = 0; i < NF; i++) begin : g_leaf
    assign nv[NF+i] = leaf[i];
    assign ni[NF+i] = IW'(i);
  end

  for (genvar n = 1; n < NF; n++) begin : g_node
    localparam int DEPTH = $clog2(n + 1) - 1;
    localparam int LVL   = L - DEPTH;

    logic [SW-1:0] win_val, val_q;
    logic [IW-1:0] win_idx, idx_q;

    pe_max_node #(.SW(SW), .IW(IW)) u_cmp (
      .a_val (nv[2*n]),
      .a_idx (ni[2*n]),
      .b_val (nv[2*n+1]),
      .b_idx (ni[2*n+1]),
      .o_val (win_val),
      .o_idx (win_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        idx_q <= '0;
      end else if (go[LVL-1]) begin
        val_q <= win_val;
        idx_q <= win_idx;
      end
    end

    assign nv[n] = val_q;
    assign ni[n] = idx_q;
  end

  assign max_val = nv[1];
  assign max_idx = ni[1];

endmodule

// File: rtl/par_eval_ctrl.sv
module par_eval_ctrl
  import pe_pkg::*;
#(
  parameter int NF = 8,
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [NF*CW-1:0]        req_cand,
  output logic                    unit_start,
  output logic [NF*CW-1:0]        unit_cand,
  input  logic [NF-1:0]           unit_done,
  input  logic [NF*SW-1:0]        unit_score,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic [SW-1:0]           res_score,
  output logic [$clog2(NF)-1:0]   res_index
);

  pe_state_e                state;
  logic                     accept, launch, cap_en, all_done, root_load;
  logic [NF-1:0][SW-1:0]    score_in, score_q;

  assign score_in = unit_score;

  pe_ctrl_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .all_done  (all_done),
    .root_load (root_load),
    .res_ready (res_ready),
    .state     (state),
    .req_ready (req_ready),
    .accept    (accept),
    .launch    (launch),
    .cap_en    (cap_en),
    .res_valid (res_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_start <= 1'b0;
      unit_cand  <= '0;
    end else begin
      unit_start <= accept;
      if (accept) unit_cand <= req_cand;
    end
  end

  pe_score_capture #(.NF(NF), .SW(SW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .cap_en   (cap_en),
    .done     (unit_done),
    .score_in (score_in),
    .score_q  (score_q),
    .all_done (all_done)
  );

  pe_max_tree #(.NF(NF), .SW(SW)) u_tree (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .leaf      (score_q),
    .root_load (root_load),
    .max_val   (res_score),
    .max_idx   (res_index)
  );

endmodule

// File: rtl/pe_eval_chk.sv
module pe_eval_chk #(
  parameter int SW = 16,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          unit_start,
  input logic          res_valid,
  input logic          res_ready,
  input logic [SW-1:0] res_score,
  input logic [IW-1:0] res_index,
  input logic          all_done
);

  AST_START_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    unit_start |-> $past(req_valid && req_ready)); // R1

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    unit_start |=> !unit_start); // R1

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(all_done) |-> $past(req_valid && req_ready)); // R2

  AST_RESULT_AFTER_BARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> all_done); // R3

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_score) && $stable(res_index)); // R6

  AST_RESULT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> !res_valid && req_ready); // R6

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !res_valid && !unit_start); // R7

endmodule

bind par_eval_ctrl pe_eval_chk #(.SW(SW), .IW($clog2(NF))) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .unit_start (unit_start),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_score  (res_score),
  .res_index  (res_index),
  .all_done   (all_done)
);

// File: tb/test_par_eval_ctrl.sv
module test_par_eval_ctrl;

  localparam int NF = 8;
  localparam int SW = 16;
  localparam int CW = 12;
  localparam int L  = $clog2(NF);
  localparam int IW = L;
  localparam int CLK_PERIOD = 10;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic [NF*CW-1:0]    req_cand = '0;
  logic                unit_start;
  logic [NF*CW-1:0]    unit_cand;
  logic [NF-1:0]       unit_done = '0;
  logic [NF*SW-1:0]    unit_score = '0;
  logic                res_valid;
  logic                res_ready = 1'b0;
  logic [SW-1:0]       res_score;
  logic [IW-1:0]       res_index;

  int n_chk = 0;
  int n_bad = 0;

  logic [SW-1:0] t_sc  [NF];
  int            t_lat [NF];
  int            t_wait;
  int            t_dup;
  bit            t_busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_eval_ctrl #(.NF(NF), .SW(SW), .CW(CW)) i_par_eval_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_cand   (req_cand),
    .unit_start (unit_start),
    .unit_cand  (unit_cand),
    .unit_done  (unit_done),
    .unit_score (unit_score),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_score  (res_score),
    .res_index  (res_index)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_index();
    int best = 0;
    for (int i = 1; i < NF; i++)
      if ($signed(t_sc[i]) > $signed(t_sc[best])) best = i;
    return best;
  endfunction

  // entered and left on a falling edge
  task automatic run_batch();
    logic [NF*CW-1:0] cand;
    int               dmax;
    int               best;
    logic [SW-1:0]    hold_s;
    logic [IW-1:0]    hold_i;

    for (int i = 0; i < NF; i++) cand[i*CW +: CW] = CW'($urandom);
    dmax = 0;
    for (int i = 0; i < NF; i++) if (t_lat[i] > dmax) dmax = t_lat[i];
    best = exp_index();

    req_cand  = cand;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R1", "req_ready when idle", longint'(req_ready), 1);
    @(negedge clk);
    // cycle 0: start strobe
    chk(unit_start == 1'b1, "R1", "unit_start after accept", longint'(unit_start), 1);
    chk(unit_cand == cand, "R1", "unit_cand slot 0", longint'(unit_cand[CW-1:0]),
        longint'(cand[CW-1:0]));
    req_valid = t_busy;
    req_cand  = ~cand;

    for (int cyc = 0; ; cyc++) begin
      if (cyc > 0) @(negedge clk);
      for (int i = 0; i < NF; i++) begin
        if (cyc == t_lat[i]) begin
          unit_done[i] = 1'b1;
          unit_score[i*SW +: SW] = t_sc[i];
        end else if (t_dup == i && cyc == t_lat[i] + 1) begin
          unit_done[i] = 1'b1;
          unit_score[i*SW +: SW] = 16'h7FFF;
        end else begin
          unit_done[i] = 1'b0;
          unit_score[i*SW +: SW] = SW'($urandom);
        end
      end
      if (cyc > 0)
        chk(unit_start == 1'b0, "R7", "no start while busy", longint'(unit_start), 0);
      if (cyc < dmax + L + 1) begin
        chk(res_valid == 1'b0, "R3", "res_valid early", longint'(res_valid), 0);
        if (cyc > 0)
          chk(req_ready == 1'b0, "R7", "req_ready while busy", longint'(req_ready), 0);
      end else begin
        chk(res_valid == 1'b1, "R3", "res_valid on time", longint'(res_valid), 1);
        break;
      end
    end
    unit_done = '0;

    chk(res_score == t_sc[best], "R4", "res_score", longint'(res_score), longint'(t_sc[best]));
    chk(int'(res_index) == best, "R5", "res_index", longint'(res_index), longint'(best));
    hold_s = res_score;
    hold_i = res_index;

    for (int w = 0; w < t_wait; w++) begin
      @(negedge clk);
      chk(res_valid == 1'b1, "R6", "res_valid held", longint'(res_valid), 1);
      chk(res_score == hold_s && res_index == hold_i, "R6", "result held",
          longint'(res_score), longint'(hold_s));
      chk(req_ready == 1'b0, "R7", "req_ready during hold", longint'(req_ready), 0);
    end
    req_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(res_valid == 1'b0, "R6", "res_valid after take", longint'(res_valid), 0);
    chk(req_ready == 1'b1, "R6", "req_ready after take", longint'(req_ready), 1);
    chk(unit_start == 1'b0, "R7", "no restart after take", longint'(unit_start), 0);
  endtask

  task automatic set_defaults();
    for (int i = 0; i < NF; i++) begin
      t_sc[i]  = SW'(i);
      t_lat[i] = i;
    end
    t_wait = 0;
    t_dup  = -1;
    t_busy = 1'b0;
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'd20240611);
    if (seed_val == 0) seed_val = 1;

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && res_valid == 1'b0 && unit_start == 1'b0, "R8",
        "outputs in reset", longint'({req_ready, res_valid, unit_start}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", "req_ready after reset", longint'(req_ready), 1);
    chk(res_valid == 1'b0, "R8", "res_valid after reset", longint'(res_valid), 0);
    chk(unit_start == 1'b0, "R8", "unit_start after reset", longint'(unit_start), 0);

    // all equal scores: lowest unit wins (R5)
    set_defaults();
    for (int i = 0; i < NF; i++) begin t_sc[i] = 16'h0100; t_lat[i] = NF - i; end
    run_batch();

    // largest at the last unit, slowest unit finishing first (R4)
    set_defaults();
    t_sc[NF-1] = 16'h0200; t_lat[NF-1] = 0; t_lat[0] = 9;
    run_batch();

    // all negative, largest is -1 at unit 5 (R4)
    set_defaults();
    for (int i = 0; i < NF; i++) t_sc[i] = SW'(-100 - i);
    t_sc[5] = 16'hFFFF;
    run_batch();

    // extremes: most negative everywhere, most positive at unit 2 (R4)
    set_defaults();
    for (int i = 0; i < NF; i++) t_sc[i] = 16'h8000;
    t_sc[2] = 16'h7FFF; t_sc[3] = 16'h0000;
    t_wait = 3;
    run_batch();

    // tie between units 3 and 6, unit 6 reporting first (R5)
    set_defaults();
    t_sc[3] = 16'h0050; t_sc[6] = 16'h0050; t_lat[6] = 0; t_lat[3] = 7;
    run_batch();

    // repeated done pulse from unit 1 with a large score is ignored (R2)
    set_defaults();
    for (int i = 0; i < NF; i++) t_lat[i] = 6;
    t_lat[1] = 0; t_sc[1] = 16'h0001; t_dup = 1;
    run_batch();

    // request held high during a batch is not taken (R7)
    set_defaults();
    t_busy = 1'b1; t_wait = 4;
    run_batch();

    // every unit done in the start cycle (R3)
    set_defaults();
    for (int i = 0; i < NF; i++) t_lat[i] = 0;
    t_sc[4] = 16'h1234;
    run_batch();

    // constrained random batches
    for (int b = 0; b < 40; b++) begin
      set_defaults();
      for (int i = 0; i < NF; i++) begin
        t_lat[i] = $urandom_range(0, 12);
        t_sc[i]  = (b % 4 == 0) ? SW'($urandom_range(0, 3)) : SW'($urandom);
      end
      t_wait = $urandom_range(0, 3);
      run_batch();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R3 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule